// File: doc/BRIEF.md
# SAR Converter Serial Output Sequencer

This block models the digital serial side of a 12-bit successive-approximation converter. A host pulls an active-low chip select down to start a frame. It then toggles a slow data clock. The block answers on a serial data line that is either driven or released, and a separate enable output marks which of the two applies. A parallel input word stands in for the comparator decisions. That word is captured when the frame starts. It is then shifted out with no pipeline delay, after a short sampling window and one low null bit.

Both the chip select and the data clock are oversampled by a fast system clock through a parameterised synchronizer, and every action happens on a detected falling edge of the data clock. After the most-significant-first word, continued clocking can replay the word least significant bit first. This variant is chosen by a parameter. The line is then released until chip select has gone high and come back low. Two status outputs report when the analog section and the digital section would be powered down.

Top module: `sar_serial_seq`

## Requirements
- R1: During and after reset, with no frame started, `sdo_oe` is 0 and both `analog_pd` and `digital_pd` are 1. Reset treats chip select as high.
- R2: A synchronized falling edge of `cs_n` starts a frame and captures `sample_in` as the word for that frame. Later changes of `sample_in` during the frame do not alter any bit sent.
- R3: The first data-clock falling edge after a frame start leaves `sdo_oe` at 0, and so does the time before it (the sampling window).
- R4: On the 2nd data-clock falling edge of a frame, `sdo_oe` becomes 1 and `sdo` carries a 0 null bit for one data-clock period.
- R5: On falling edges 3 through 14, `sdo` carries word bits 11 down to 0, one bit per edge.
- R6: With `REPLAY_LSB`=1, falling edges 15 through 25 carry word bits 1 up to 11. Bit 0 is not sent a second time.
- R7: From falling edge 26 onward, `sdo_oe` stays 0 for as long as `cs_n` stays low, whatever the data clock does.
- R8: Raising `cs_n` at any point ends the frame and sets `sdo_oe` to 0. A new frame needs `cs_n` to go high and then low again, and it restarts the edge count from zero.
- R9: `digital_pd` is 0 exactly while a frame is open (chip select low). `analog_pd` is 0 only from frame start until the falling edge that launches bit 0, and is 1 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select, asynchronous to clk |
| dclk | input | 1 | External data clock, asynchronous to clk |
| sample_in | input | WIDTH | Conversion result standing in for the comparator |
| sdo | output | 1 | Serial data bit, meaningful while sdo_oe is 1 |
| sdo_oe | output | 1 | Output driver enable; 0 means high impedance |
| analog_pd | output | 1 | Analog section powered down |
| digital_pd | output | 1 | Digital section powered down |

## Verification
The assertions assume that `cs_n` and `dclk` each hold every level for at least three system clocks. This makes each edge produce exactly one synchronized edge. The assertions also assume that a chip-select edge and a data-clock falling edge never reach the synchronizer output on the same clock. The stimulus keeps to this by holding each data-clock level for eight system clocks. It moves chip select only while the data clock is low and at least eight clocks after its last edge. Random frames draw the word and the number of data-clock periods from a seeded generator. Directed frames cover all-ones, all-zeros, mid-scale, early termination and clocking past the released state.

// File: rtl/sarq_pkg.sv
package sarq_pkg;

   // Output window of the frame, decoded from the falling-edge count.
   typedef enum logic [2:0] {
      WIN_IDLE   = 3'd0,
      WIN_SAMPLE = 3'd1,
      WIN_NULL   = 3'd2,
      WIN_MSB    = 3'd3,
      WIN_LSB    = 3'd4,
      WIN_OFF    = 3'd5
   } win_e;

   // Edge count on which the null bit is launched.
   function automatic int null_edge(input int sample_falls);
      return sample_falls;
   endfunction

   // Edge count on which bit 0 is launched in the MSB-first pass.
   function automatic int lsb_edge(input int sample_falls, input int width);
      return sample_falls + width;
   endfunction

   // Last edge count that still drives data.
   function automatic int last_edge(input int sample_falls, input int width, input bit replay);
      return replay ? (sample_falls + 2 * width - 1) : (sample_falls + width);
   endfunction

   // Edge count at which the output is released for good.
   function automatic int off_edge(input int sample_falls, input int width, input bit replay);
      return last_edge(sample_falls, width, replay) + 1;
   endfunction

endpackage

// File: rtl/sarq_sync.sv
module sarq_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain <= {STAGES{RESET_VAL}};
            end else begin
               chain <= {chain[STAGES-2:0], d};
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sarq_frame_ctl.sv
module sarq_frame_ctl #(
   parameter int WIDTH        = 12,
   parameter int SAMPLE_FALLS = 2,
   parameter bit REPLAY_LSB   = 1'b1,
   parameter int CNT_W        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s,
   input  logic             dclk_s,
   input  logic [WIDTH-1:0] sample_in,
   output logic             active,
   output logic [CNT_W-1:0] cnt,
   output logic [WIDTH-1:0] word
);
   import sarq_pkg::*;

   localparam int OFF_AT = off_edge(SAMPLE_FALLS, WIDTH, REPLAY_LSB);
   localparam logic [CNT_W-1:0] OFF_C = CNT_W'(OFF_AT);

   logic cs_prev;
   logic dclk_prev;
   logic cs_fall;
   logic dclk_fall;
   logic cnt_run;

   // Reset treats chip select as high, so a low level afterwards is a start.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         dclk_prev <= 1'b0;
      end else begin
         cs_prev   <= cs_s;
         dclk_prev <= dclk_s;
      end
   end

   assign cs_fall   = cs_prev & ~cs_s;
   assign dclk_fall = dclk_prev & ~dclk_s;
   assign cnt_run   = active & dclk_fall & (cnt != OFF_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         word   <= '0;
      end else if (cs_s) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (cs_fall) begin
         active <= 1'b1;
         cnt    <= '0;
         word   <= sample_in;
      end else if (cnt_run) begin
         cnt    <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/sarq_bit_sel.sv
module sarq_bit_sel #(
   parameter int WIDTH        = 12,
   parameter int SAMPLE_FALLS = 2,
   parameter bit REPLAY_LSB   = 1'b1,
   parameter int CNT_W        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] cnt,
   input  logic [WIDTH-1:0] word,
   output logic             sdo,
   output logic             sdo_oe
);
   import sarq_pkg::*;

   localparam int IDX_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int NULL_AT = null_edge(SAMPLE_FALLS);
   localparam int LSB_AT  = lsb_edge(SAMPLE_FALLS, WIDTH);
   localparam int LAST_AT = last_edge(SAMPLE_FALLS, WIDTH, REPLAY_LSB);
   localparam logic [CNT_W-1:0] NULL_C = CNT_W'(NULL_AT);
   localparam logic [CNT_W-1:0] LSB_C  = CNT_W'(LSB_AT);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_AT);

   win_e             win;
   logic             in_replay;
   logic [CNT_W-1:0] down_dist;
   logic [CNT_W-1:0] up_dist;
   logic [IDX_W-1:0] msb_idx;
   logic [IDX_W-1:0] lsb_idx;
   logic             nxt_bit;
   logic             nxt_oe;

   // Replay window exists only in the variant that sends LSB-first data.
   generate
      if (REPLAY_LSB) begin : g_replay
         assign in_replay = (cnt > LSB_C) && (cnt <= LAST_C);
      end else begin : g_single
         assign in_replay = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!active) begin
         win = WIN_IDLE;
      end else if (cnt < NULL_C) begin
         win = WIN_SAMPLE;
      end else if (cnt == NULL_C) begin
         win = WIN_NULL;
      end else if (cnt <= LSB_C) begin
         win = WIN_MSB;
      end else if (in_replay) begin
         win = WIN_LSB;
      end else begin
         win = WIN_OFF;
      end
   end

   // Distance to the bit-0 edge gives the MSB-first index; distance past it the replay index.
   assign down_dist = LSB_C - cnt;
   assign up_dist   = cnt - LSB_C;
   assign msb_idx   = down_dist[IDX_W-1:0];
   assign lsb_idx   = up_dist[IDX_W-1:0];

   always_comb begin
      case (win)
         WIN_MSB: nxt_bit = word[msb_idx];
         WIN_LSB: nxt_bit = word[lsb_idx];
         default: nxt_bit = 1'b0;
      endcase
      nxt_oe = (win == WIN_NULL) || (win == WIN_MSB) || (win == WIN_LSB);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sdo    <= 1'b0;
         sdo_oe <= 1'b0;
      end else begin
         sdo    <= nxt_bit;
         sdo_oe <= nxt_oe;
      end
   end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
   parameter int WIDTH        = 12,
   parameter int SAMPLE_FALLS = 2,
   parameter bit REPLAY_LSB   = 1'b1,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             dclk,
   input  logic [WIDTH-1:0] sample_in,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             analog_pd,
   output logic             digital_pd
);
   import sarq_pkg::*;

   localparam int OFF_AT = off_edge(SAMPLE_FALLS, WIDTH, REPLAY_LSB);
   localparam int CNT_W  = $clog2(OFF_AT + 1);
   localparam int LSB_AT = lsb_edge(SAMPLE_FALLS, WIDTH);
   localparam logic [CNT_W-1:0] LSB_C = CNT_W'(LSB_AT);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sar_serial_seq: WIDTH must be at least 2");
      end
      if (SAMPLE_FALLS < 1) begin : g_bad_window
         $error("sar_serial_seq: SAMPLE_FALLS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("sar_serial_seq: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic             cs_s;
   logic             dclk_s;
   logic             active;
   logic [CNT_W-1:0] cnt;
   logic [WIDTH-1:0] word_q;

   sarq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
   );

   sarq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_dclk_sync (
      .clk(clk), .rst_n(rst_n), .d(dclk), .q(dclk_s)
   );

   sarq_frame_ctl #(
      .WIDTH(WIDTH), .SAMPLE_FALLS(SAMPLE_FALLS),
      .REPLAY_LSB(REPLAY_LSB), .CNT_W(CNT_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .dclk_s(dclk_s),
      .sample_in(sample_in), .active(active), .cnt(cnt), .word(word_q)
   );

   sarq_bit_sel #(
      .WIDTH(WIDTH), .SAMPLE_FALLS(SAMPLE_FALLS),
      .REPLAY_LSB(REPLAY_LSB), .CNT_W(CNT_W)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .active(active), .cnt(cnt),
      .word(word_q), .sdo(sdo), .sdo_oe(sdo_oe)
   );

   // Digital side sleeps outside a frame; analog side also sleeps once bit 0 is decided.
   assign digital_pd = ~active;
   assign analog_pd  = ~(active && (cnt < LSB_C));

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
   parameter int WIDTH = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sdo,
   input logic             sdo_oe,
   input logic             analog_pd,
   input logic             digital_pd,
   input logic [WIDTH-1:0] word
);

   // R8: with chip select high for two clocks the line is released
   a_r8_cs_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (digital_pd && $past(digital_pd)) |-> !sdo_oe);

   // R4: the first driven bit of a frame is the low null bit
   a_r4_null_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> !sdo);

   // R7: release with chip select still low only happens after conversion end
   a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sdo_oe) && !digital_pd) |-> analog_pd);

   // R2: captured word does not move inside a frame
   a_r2_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!digital_pd && $past(!digital_pd)) |-> $stable(word));

   // R3: frame opens in the sampling window, output still released
   a_r3_window_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(digital_pd) |=> !sdo_oe);

   // R9: analog section wakes together with the digital section
   a_r9_analog_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(digital_pd) |-> !analog_pd);

endmodule

bind sar_serial_seq sar_serial_seq_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe),
   .analog_pd(analog_pd), .digital_pd(digital_pd), .word(word_q)
);

// File: tb/tb_sar_serial_seq.sv
module tb_sar_serial_seq;

   localparam int W    = 12;
   localparam int HALF = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cs_n = 1'b1;
   logic         dclk = 1'b0;
   logic [W-1:0] sample_in = '0;
   logic         sdo;
   logic         sdo_oe;
   logic         analog_pd;
   logic         digital_pd;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   always #5 clk = ~clk;

   sar_serial_seq dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk),
      .sample_in(sample_in), .sdo(sdo), .sdo_oe(sdo_oe),
      .analog_pd(analog_pd), .digital_pd(digital_pd)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   // Expected enable after falling edge f of a frame (R3..R7)
   function automatic logic exp_oe(input int f);
      return (f >= 2) && (f <= 25);
   endfunction

   // Expected data after falling edge f (R4 null, R5 MSB-first, R6 replay)
   function automatic logic exp_bit(input int f, input logic [W-1:0] w);
      if (f >= 3 && f <= 14) return w[14 - f];
      if (f >= 15 && f <= 25) return w[f - 14];
      return 1'b0;
   endfunction

   function automatic string req_of(input int f);
      if (f < 2)   return "R3";
      if (f == 2)  return "R4";
      if (f <= 14) return "R5";
      if (f <= 25) return "R6";
      return "R7";
   endfunction

   // One frame: chip select low, nfall data-clock periods, chip select high.
   task automatic run_frame(input logic [W-1:0] w, input int nfall);
      sample_in = w;
      cs_n = 1'b0;
      tick(HALF);
      check("R3", "oe in sampling window", sdo_oe, 1'b0);
      check("R9", "digital_pd in frame", digital_pd, 1'b0);
      check("R9", "analog_pd at start", analog_pd, 1'b0);
      sample_in = ~w;  // R2: must not affect this frame
      for (int f = 1; f <= nfall; f++) begin
         dclk = 1'b1;
         tick(HALF);
         dclk = 1'b0;
         tick(HALF);
         check(req_of(f), $sformatf("oe edge %0d", f), sdo_oe, exp_oe(f));
         if (exp_oe(f))
            check(f > 2 ? "R2" : "R4", $sformatf("bit edge %0d", f), sdo, exp_bit(f, w));
         check("R9", $sformatf("analog_pd edge %0d", f), analog_pd, (f >= 14));
      end
      cs_n = 1'b1;
      tick(HALF);
      check("R8", "oe after cs high", sdo_oe, 1'b0);
      check("R9", "digital_pd after cs high", digital_pd, 1'b1);
      check("R9", "analog_pd after cs high", analog_pd, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd20241));
      tick(4);
      check("R1", "oe in reset", sdo_oe, 1'b0);
      rst_n = 1'b1;
      tick(HALF);
      check("R1", "oe after reset", sdo_oe, 1'b0);
      check("R1", "analog_pd after reset", analog_pd, 1'b1);
      check("R1", "digital_pd after reset", digital_pd, 1'b1);

      // Directed corner words, full replay
      run_frame(12'hFFF, 26);
      run_frame(12'h000, 26);
      run_frame(12'h800, 26);
      run_frame(12'h7FF, 26);
      run_frame(12'hA5C, 25);

      // R7: clocking past release keeps the line released
      run_frame(12'h3C1, 32);

      // R8: early termination, then a fresh frame counts from zero
      run_frame(12'h5A5, 7);
      run_frame(12'h1E7, 1);
      run_frame(12'hC33, 20);

      // Random frames
      for (int k = 0; k < 20; k++) begin
         run_frame(W'($urandom), 1 + int'($urandom % 30));
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule